// File: doc/BRIEF.md
# Sectioned Instruction Memory Port

This block is a small register-file memory that holds eight wide instructions for a conversion sequencer. Each instruction is 48 bits: a control section and two limit sections of 16 bits each. A host reaches the memory through a narrow bus, one 16-bit section at a time. The bus address picks the instruction, and a 2-bit section pointer, taken from a configuration register elsewhere, picks the section within it.

The host bus is either 16 bits or 8 bits wide, chosen by a mode input. In 8-bit mode the lowest address bit picks the byte lane inside the selected section, so each instruction takes two addresses. The sequencer reads whole 48-bit instructions through its own read port. A busy input from the sequencer marks the periods when host access is not allowed. An access made while busy raises a violation flag, and a write made while busy is dropped. The host is expected to stop the sequencer before any access and to issue a soft reset afterwards. Reads return data one cycle after the request, marked by a valid pulse. Reads cannot be held back, so there is no ready signal.

Top module: `sect_imem_port`

## Requirements
- R1: After reset every section of every instruction reads as zero, and `rd_valid` and `viol` are low.
- R2: With `byte_mode`=0, a write stores all 16 bits of `host_wdata` into section `sect_ptr` (0 control, 1 first limit, 2 second limit) of instruction `host_addr[3:1]`. Address bit 0 is ignored. The new value is visible on the sequencer port after the next clock edge.
- R3: A cycle with `host_rd` high gives `rd_valid` high in the next cycle, with `rd_data` holding the addressed section. `rd_valid` is low in every other cycle.
- R4: With `byte_mode`=1, an even address refers to bits 7:0 and an odd address refers to bits 15:8 of the selected section. A write changes only that byte, taken from `host_wdata[7:0]`. A read returns that byte in `rd_data[7:0]` with bits 15:8 zero.
- R5: Section pointer value 3 is reserved. Writes with it change nothing, and reads with it return zero.
- R6: An address with bit 4 set lies outside the memory in both bus modes. Writes to it change nothing, and reads from it return zero.
- R7: A read or write made while `seq_busy` is high sets `viol` high for exactly the next cycle, and such a write changes nothing. Otherwise `viol` is low.
- R8: `seq_instr` shows, without a clock delay, the instruction selected by `seq_idx`, packed as {second limit, first limit, control} with the control section in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_mode | input | 1 | 1 selects the 8-bit host bus, 0 the 16-bit bus |
| sect_ptr | input | 2 | Section pointer from the configuration register |
| host_addr | input | 5 | Host address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| rd_valid | output | 1 | Read data valid, one cycle after `host_rd` |
| rd_data | output | 16 | Read data |
| seq_busy | input | 1 | Sequencer running; host access is illegal |
| viol | output | 1 | Access-violation pulse |
| seq_idx | input | 3 | Sequencer instruction index |
| seq_instr | output | 48 | Selected 48-bit instruction |

## Verification
The bound checker checks on every cycle that the read-valid and violation pulses follow their requests by exactly one cycle. It also checks that a dropped write (made while busy, with the reserved pointer, or to an out-of-range address) leaves the viewed instruction unchanged, and that byte-mode and reserved-pointer reads return zeros where required. Only the bench scenarios can show that the data lands in the right instruction, section and byte lane. They also show that the untouched byte of a section keeps its value, and that reset clears contents that were written earlier.

// File: rtl/imem_pkg.sv
package imem_pkg;
  typedef enum logic [1:0] {
    SEC_CTRL = 2'd0,
    SEC_LIM1 = 2'd1,
    SEC_LIM2 = 2'd2,
    SEC_RSVD = 2'd3
  } sect_e;
endpackage

// File: rtl/imem_addr_dec.sv
module imem_addr_dec #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_mode,
  input  logic [1:0]        sect_ptr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output logic              sect_ok,
  output logic              hi_lane
);
  import imem_pkg::*;

  // bit 0 is the lane bit in byte mode and a don't-care in word mode
  assign idx      = addr[IDX_W:1];
  assign in_range = ~|addr[ADDR_W-1:IDX_W+1];
  assign sect_ok  = (sect_e'(sect_ptr) != SEC_RSVD);
  assign hi_lane  = byte_mode & addr[0];
endmodule

// File: rtl/imem_lane.sv
module imem_lane #(
  parameter int SECT_W = 16
) (
  input  logic [SECT_W-1:0] old_i,
  input  logic [SECT_W-1:0] wdata_i,
  input  logic              byte_mode,
  input  logic              hi_lane,
  output logic [SECT_W-1:0] merged_o,
  output logic [SECT_W-1:0] rd_o
);
  localparam int LANE_W = SECT_W / 2;

  always_comb begin
    merged_o = wdata_i;
    rd_o     = old_i;
    if (byte_mode) begin
      rd_o = '0;
      if (hi_lane) begin
        merged_o = {wdata_i[LANE_W-1:0], old_i[LANE_W-1:0]};
        rd_o[LANE_W-1:0] = old_i[SECT_W-1:LANE_W];
      end else begin
        merged_o = {old_i[SECT_W-1:LANE_W], wdata_i[LANE_W-1:0]};
        rd_o[LANE_W-1:0] = old_i[LANE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/imem_bank.sv
module imem_bank #(
  parameter int N_INSTR = 8,
  parameter int N_SECT  = 3,
  parameter int SECT_W  = 16,
  localparam int IDX_W  = $clog2(N_INSTR),
  localparam int WORD_W = N_SECT * SECT_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [IDX_W-1:0]               widx,
  input  logic [1:0]                     wsec,
  input  logic [SECT_W-1:0]              wword,
  output logic [N_INSTR-1:0][WORD_W-1:0] words
);
  for (genvar i = 0; i < N_INSTR; i++) begin : g_instr
    for (genvar s = 0; s < N_SECT; s++) begin : g_sect
      logic hit;
      assign hit = we && (widx == IDX_W'(i)) && (wsec == 2'(s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   words[i][s*SECT_W +: SECT_W] <= '0;
        else if (hit) words[i][s*SECT_W +: SECT_W] <= wword;
      end
    end
  end
endmodule

// File: rtl/sect_imem_port.sv
module sect_imem_port #(
  parameter int N_INSTR = 8,
  parameter int N_SECT  = 3,
  parameter int SECT_W  = 16,
  parameter int ADDR_W  = 5,
  localparam int IDX_W  = $clog2(N_INSTR),
  localparam int WORD_W = N_SECT * SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic [1:0]        sect_ptr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [SECT_W-1:0] host_wdata,
  output logic              rd_valid,
  output logic [SECT_W-1:0] rd_data,
  input  logic              seq_busy,
  output logic              viol,
  input  logic [IDX_W-1:0]  seq_idx,
  output logic [WORD_W-1:0] seq_instr
);
  logic [IDX_W-1:0]               idx;
  logic                           in_range, sect_ok, hi_lane;
  logic [1:0]                     sel_sec;
  logic [SECT_W-1:0]              cur_sect, merged, lane_rd;
  logic                           wr_ok;
  logic [N_INSTR-1:0][WORD_W-1:0] words;

  imem_addr_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(host_addr), .byte_mode(byte_mode), .sect_ptr(sect_ptr),
    .idx(idx), .in_range(in_range), .sect_ok(sect_ok), .hi_lane(hi_lane)
  );

  // reserved pointer is steered to section 0 only to keep the index legal
  assign sel_sec  = sect_ok ? sect_ptr : 2'd0;
  assign cur_sect = words[idx][sel_sec*SECT_W +: SECT_W];

  imem_lane #(.SECT_W(SECT_W)) u_lane (
    .old_i(cur_sect), .wdata_i(host_wdata), .byte_mode(byte_mode),
    .hi_lane(hi_lane), .merged_o(merged), .rd_o(lane_rd)
  );

  assign wr_ok = host_wr && !seq_busy && in_range && sect_ok;

  imem_bank #(.N_INSTR(N_INSTR), .N_SECT(N_SECT), .SECT_W(SECT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_ok), .widx(idx), .wsec(sel_sec),
    .wword(merged), .words(words)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      viol     <= 1'b0;
    end else begin
      rd_valid <= host_rd;
      viol     <= (host_rd || host_wr) && seq_busy;
      if (host_rd) rd_data <= (in_range && sect_ok) ? lane_rd : '0;
    end
  end

  assign seq_instr = words[seq_idx];
endmodule

// File: rtl/sect_imem_port_chk.sv
module sect_imem_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_mode,
  input logic [1:0]  sect_ptr,
  input logic [4:0]  host_addr,
  input logic        host_wr,
  input logic        host_rd,
  input logic        seq_busy,
  input logic [2:0]  seq_idx,
  input logic [47:0] seq_instr,
  input logic        rd_valid,
  input logic [15:0] rd_data,
  input logic        viol
);
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> rd_valid);
  a_r3_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !rd_valid);
  a_r7_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd || host_wr) && seq_busy) |=> viol);
  a_r7_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !((host_rd || host_wr) && seq_busy) |=> !viol);
  a_r7_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && seq_busy) |=> (!$stable(seq_idx) || $stable(seq_instr)));
  a_r5_rsvd_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && sect_ptr == 2'd3) |=> (!$stable(seq_idx) || $stable(seq_instr)));
  a_r6_far_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr[4]) |=> (!$stable(seq_idx) || $stable(seq_instr)));
  a_r5_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && sect_ptr == 2'd3) |=> (rd_data == 16'h0));
  a_r4_byte_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && byte_mode) |=> (rd_data[15:8] == 8'h0));
endmodule

bind sect_imem_port sect_imem_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .sect_ptr(sect_ptr),
  .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
  .seq_busy(seq_busy), .seq_idx(seq_idx), .seq_instr(seq_instr),
  .rd_valid(rd_valid), .rd_data(rd_data), .viol(viol)
);

// File: tb/sect_imem_port_tb.sv
module sect_imem_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_mode = 1'b0;
  logic [1:0]  sect_ptr = 2'd0;
  logic [4:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        seq_busy = 1'b0;
  logic [2:0]  seq_idx = '0;
  logic        rd_valid, viol;
  logic [15:0] rd_data;
  logic [47:0] seq_instr;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sect_imem_port u_dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .sect_ptr(sect_ptr),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .seq_busy(seq_busy), .viol(viol), .seq_idx(seq_idx), .seq_instr(seq_instr)
  );

  typedef struct packed {
    logic        wr;
    logic        bm;
    logic [1:0]  ptr;
    logic [4:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 2'd0, 5'h02, 16'h1234, 16'h0000},  // R2 ctrl idx1
    '{1'b1, 1'b0, 2'd1, 5'h02, 16'hA5C3, 16'h0000},  // R2 lim1 idx1
    '{1'b1, 1'b0, 2'd2, 5'h0E, 16'h7F01, 16'h0000},  // R2 lim2 idx7
    '{1'b0, 1'b0, 2'd0, 5'h02, 16'h0000, 16'h1234},  // R3
    '{1'b0, 1'b0, 2'd1, 5'h03, 16'h0000, 16'hA5C3},  // R2 bit0 ignored
    '{1'b0, 1'b0, 2'd2, 5'h0E, 16'h0000, 16'h7F01},  // R3
    '{1'b1, 1'b1, 2'd0, 5'h03, 16'h00BE, 16'h0000},  // R4 high byte
    '{1'b0, 1'b0, 2'd0, 5'h02, 16'h0000, 16'hBE34},  // R4 low kept
    '{1'b1, 1'b1, 2'd2, 5'h0E, 16'hFF99, 16'h0000},  // R4 low byte
    '{1'b0, 1'b1, 2'd2, 5'h0E, 16'h0000, 16'h0099},  // R4 even read
    '{1'b0, 1'b1, 2'd2, 5'h0F, 16'h0000, 16'h007F},  // R4 odd read
    '{1'b1, 1'b0, 2'd3, 5'h02, 16'hFFFF, 16'h0000},  // R5 write
    '{1'b0, 1'b0, 2'd3, 5'h02, 16'h0000, 16'h0000},  // R5 read
    '{1'b1, 1'b0, 2'd0, 5'h12, 16'hDEAD, 16'h0000},  // R6 write
    '{1'b0, 1'b0, 2'd0, 5'h02, 16'h0000, 16'hBE34},  // R6 no alias
    '{1'b0, 1'b0, 2'd0, 5'h12, 16'h0000, 16'h0000},  // R6 read
    '{1'b0, 1'b1, 2'd0, 5'h1F, 16'h0000, 16'h0000}   // R6 byte mode
  };

  task automatic check(string tag, logic [47:0] got, logic [47:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one access at a falling edge; results sampled one clock later
  task automatic access(logic wr, logic bm, logic [1:0] ptr, logic [4:0] a,
                        logic [15:0] d);
    @(negedge clk);
    host_wr = wr; host_rd = ~wr; byte_mode = bm; sect_ptr = ptr;
    host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_valid", 48'(rd_valid), 48'h0);
    check("R1 viol", 48'(viol), 48'h0);
    seq_idx = 3'd1; #1;
    check("R1 contents", seq_instr, 48'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].bm, VEC[i].ptr, VEC[i].addr, VEC[i].data);
      if (!VEC[i].wr) begin
        check("R3 valid", 48'(rd_valid), 48'h1);
        check("R2-R6 rd_data", 48'(rd_data), 48'(VEC[i].exp));
      end
    end
    @(negedge clk);
    check("R3 valid drops", 48'(rd_valid), 48'h0);

    // R8 sequencer port packing
    seq_idx = 3'd1; #1;
    check("R8 idx1", seq_instr, 48'h0000_A5C3_BE34);
    seq_idx = 3'd7; #1;
    check("R8 idx7", seq_instr, 48'h7F99_0000_0000);

    // R7 busy access flagged and dropped
    seq_busy = 1'b1;
    access(1'b1, 1'b0, 2'd0, 5'h02, 16'h5555);
    check("R7 viol on write", 48'(viol), 48'h1);
    seq_idx = 3'd1; #1;
    check("R7 write dropped", seq_instr, 48'h0000_A5C3_BE34);
    @(negedge clk);
    check("R7 viol single cycle", 48'(viol), 48'h0);
    access(1'b0, 1'b0, 2'd0, 5'h02, 16'h0000);
    check("R7 viol on read", 48'(viol), 48'h1);
    seq_busy = 1'b0;
    access(1'b0, 1'b0, 2'd1, 5'h02, 16'h0000);
    check("R7 no viol when idle", 48'(viol), 48'h0);

    // R1 reset clears written contents
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    seq_idx = 3'd7; #1;
    check("R1 cleared idx7", seq_instr, 48'h0);
    check("R1 viol after reset", 48'(viol), 48'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule